// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block sits beside a processor pipeline and takes over the control-flow change when an interrupt or exception is pending. It receives one request line per priority class, each carrying an 8-bit vector, picks the most urgent eligible class, and runs the entry sequence. It saves four state words (and, for some vectors, an error code) through a stack write port. It converts the vector into a descriptor-table address, bounded by a base and a limit, and reads the 8-byte descriptor over a simple read port. It then presents the handler selector, offset and access bits on a one-cycle redirect output.

External maskable interrupts live in one class, and that class is gated by an interrupt-enable flag. Exception classes are never gated. If a vector's descriptor would fall past the table limit, the block substitutes a protection-fault vector and reports the offending vector in the error code. A return request pops the four saved words in the opposite order and hands them back on a one-cycle restore output.

Top module: `irq_entry_seq`

## Requirements
- R1: When several classes request at once, the block takes the eligible class with the lowest index. One cycle after dispatch, `ack` carries a one-hot mask of that class, and it never carries more than one bit.
- R2: While `if_flag` is 0, a request in class `MASK_CLS` (default 5) is ignored: no acknowledge and no stack traffic. Requests in all other classes are still taken. Once `if_flag` is 1, the class-5 request is taken.
- R3: Each entry issues exactly one descriptor read, at byte address `tbl_base + 8*vector`.
- R4: If `8*vector + 7` exceeds `tbl_limit`, the block dispatches vector 13 instead. The pushed error code is `(vector << 3) | 2`, and the descriptor for vector 13 is read without a bound check. A vector whose last descriptor byte equals the limit is dispatched normally.
- R5: Entry pushes, one word per cycle, in the order: stack segment, flags, code segment, return address.
- R6: For vectors 8, 10, 11, 12, 13, 14 and 17, a fifth word (the error code) is pushed after the return address. All other vectors push exactly four words.
- R7: The redirect output takes the selector from descriptor bits [31:16], the offset from {bits [63:48], bits [15:0]} and the access field from bits [47:32]. It also reports the dispatched vector.
- R8: `redir_valid` is high for exactly one cycle, after all pushes and the descriptor read are complete. `busy` is high from the acknowledge cycle through the redirect cycle and low on the cycle after.
- R9: No request is dispatched while `busy` is high, even one of higher priority. Such a request is taken once the current entry has finished.
- R10: A `ret_req` in idle issues four pops, with `stk_rdata` valid the cycle after each pop. The popped words are returned as return address, code segment, flags and stack segment, with `ret_valid` high for one cycle.
- R11: After reset, `busy`, `ack`, `redir_valid`, `ret_valid`, `stk_push`, `stk_pop` and `mem_rd_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | NCLS | Request per priority class (index 0 most urgent) |
| req_vec_flat | input | NCLS*8 | Vector per class, class i in bits [8i+7:8i] |
| if_flag | input | 1 | Interrupt-enable flag gating class MASK_CLS |
| err_code | input | DATA_W | Error code pushed for error-carrying vectors |
| cur_ss | input | DATA_W | Current stack segment word |
| cur_flags | input | DATA_W | Current flags word |
| cur_cs | input | DATA_W | Current code segment word |
| cur_eip | input | DATA_W | Return address |
| tbl_base | input | ADDR_W | Descriptor table base address |
| tbl_limit | input | LIM_W | Descriptor table byte limit (last valid byte) |
| ret_req | input | 1 | Return-from-interrupt request |
| ack | output | NCLS | One-hot acknowledge of the dispatched class |
| busy | output | 1 | Entry or return sequence in progress |
| mem_rd_req | output | 1 | Descriptor read strobe |
| mem_rd_addr | output | ADDR_W | Descriptor read address |
| mem_rd_valid | input | 1 | Descriptor read data valid |
| mem_rd_data | input | 64 | Descriptor read data |
| stk_push | output | 1 | Stack push strobe |
| stk_wdata | output | DATA_W | Stack push data |
| stk_pop | output | 1 | Stack pop strobe |
| stk_rdata | input | DATA_W | Popped word, valid the cycle after the pop |
| redir_valid | output | 1 | One-cycle redirect pulse |
| redir_vec | output | 8 | Dispatched vector |
| redir_sel | output | 16 | Handler code segment selector |
| redir_off | output | 32 | Handler offset |
| redir_attr | output | 16 | Descriptor access field |
| ret_valid | output | 1 | One-cycle restore pulse |
| ret_eip | output | DATA_W | Restored return address |
| ret_cs | output | DATA_W | Restored code segment |
| ret_flags | output | DATA_W | Restored flags |
| ret_ss | output | DATA_W | Restored stack segment |

## Verification
The bench first goes after the table bound. A vector whose descriptor ends exactly on the limit must be dispatched as itself, and the next vector up must turn into vector 13. An off-by-one compare would either fault the boundary vector or fetch past the table. Masking is probed with only the maskable class pending and the flag clear: a wrong gate shows up as an acknowledge or stray pushes. A priority inversion or a preempting dispatch during a running entry shows up as the wrong acknowledge or vector. Error-code vectors are mixed with plain ones, so a wrong lookup shows as a stack depth of four instead of five, or the reverse. A return after an entry compares all four restored words, which catches a pop order that was not reversed.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  localparam int VEC_W  = 8;
  localparam int DESC_W = 64;
  localparam logic [VEC_W-1:0] GP_VEC = 8'd13;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PUSH,
    S_FREQ,
    S_FWAIT,
    S_REDIR,
    S_POP,
    S_RDONE
  } seq_state_t;

  // Gate descriptor layout, most significant field first
  typedef struct packed {
    logic [15:0] off_hi;
    logic [15:0] attr;
    logic [15:0] sel;
    logic [15:0] off_lo;
  } gate_desc_t;

  // Vectors whose entry pushes an error code as the last word
  function automatic logic vec_has_err(input logic [VEC_W-1:0] v);
    case (v)
      8'd8, 8'd10, 8'd11, 8'd12, 8'd13, 8'd14, 8'd17: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_seq_pkg::*;
#(
  parameter int NCLS     = 8,
  parameter int MASK_CLS = 5
) (
  input  logic [NCLS-1:0]            req,
  input  logic [NCLS-1:0][VEC_W-1:0] req_vec,
  input  logic                       ie,
  output logic                       hit,
  output logic [NCLS-1:0]            grant,
  output logic [VEC_W-1:0]           vec
);

  logic [NCLS-1:0] elig;

  for (genvar g = 0; g < NCLS; g++) begin : g_elig
    if (g == MASK_CLS) begin : g_masked
      assign elig[g] = req[g] & ie;
    end else begin : g_plain
      assign elig[g] = req[g];
    end
  end

  // Scan from least to most urgent so the lowest index wins
  always_comb begin
    hit   = 1'b0;
    grant = '0;
    vec   = '0;
    for (int i = NCLS - 1; i >= 0; i--) begin
      if (elig[i]) begin
        hit      = 1'b1;
        grant    = '0;
        grant[i] = 1'b1;
        vec      = req_vec[i];
      end
    end
  end

endmodule

// File: rtl/irq_tbl_index.sv
module irq_tbl_index
  import irq_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LIM_W  = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [LIM_W-1:0]  limit,
  input  logic [VEC_W-1:0]  vec,
  output logic [ADDR_W-1:0] addr,
  output logic              in_range
);

  localparam int OFF_W = VEC_W + 3;
  localparam int CMP_W = (LIM_W > OFF_W) ? LIM_W : OFF_W;

  logic [OFF_W-1:0] first_byte;
  logic [OFF_W-1:0] last_byte;

  assign first_byte = {vec, 3'b000};
  assign last_byte  = {vec, 3'b111};
  assign addr       = base + ADDR_W'(first_byte);
  assign in_range   = CMP_W'(last_byte) <= CMP_W'(limit);

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int NCLS     = 8,
  parameter int MASK_CLS = 5,
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int LIM_W    = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCLS-1:0]       req,
  input  logic [NCLS*VEC_W-1:0] req_vec_flat,
  input  logic                  if_flag,
  input  logic [DATA_W-1:0]     err_code,
  input  logic [DATA_W-1:0]     cur_ss,
  input  logic [DATA_W-1:0]     cur_flags,
  input  logic [DATA_W-1:0]     cur_cs,
  input  logic [DATA_W-1:0]     cur_eip,
  input  logic [ADDR_W-1:0]     tbl_base,
  input  logic [LIM_W-1:0]      tbl_limit,
  input  logic                  ret_req,
  output logic [NCLS-1:0]       ack,
  output logic                  busy,
  output logic                  mem_rd_req,
  output logic [ADDR_W-1:0]     mem_rd_addr,
  input  logic                  mem_rd_valid,
  input  logic [DESC_W-1:0]     mem_rd_data,
  output logic                  stk_push,
  output logic [DATA_W-1:0]     stk_wdata,
  output logic                  stk_pop,
  input  logic [DATA_W-1:0]     stk_rdata,
  output logic                  redir_valid,
  output logic [VEC_W-1:0]      redir_vec,
  output logic [15:0]           redir_sel,
  output logic [31:0]           redir_off,
  output logic [15:0]           redir_attr,
  output logic                  ret_valid,
  output logic [DATA_W-1:0]     ret_eip,
  output logic [DATA_W-1:0]     ret_cs,
  output logic [DATA_W-1:0]     ret_flags,
  output logic [DATA_W-1:0]     ret_ss
);

  localparam int NWORD_MAX = 5;
  localparam int NPOP      = 4;
  localparam int CNT_W     = $clog2(NWORD_MAX + 1);

  seq_state_t                 state;
  logic [CNT_W-1:0]           cnt;
  logic [CNT_W-1:0]           nwords;
  logic [VEC_W-1:0]           vec_q;
  logic [ADDR_W-1:0]          addr_q;
  logic [DATA_W-1:0]          wbuf [0:NWORD_MAX-1];
  logic [DATA_W-1:0]          rbuf [0:NPOP-1];
  logic [1:0]                 ridx;
  logic                       pop_d;
  logic [NCLS-1:0]            ack_q;
  logic                       busy_q;
  logic [VEC_W-1:0]           rvec_q;
  logic [15:0]                rsel_q;
  logic [31:0]                roff_q;
  logic [15:0]                rattr_q;

  logic [NCLS-1:0][VEC_W-1:0] cls_vec;
  logic                       arb_hit;
  logic [NCLS-1:0]            arb_grant;
  logic [VEC_W-1:0]           arb_vec;
  logic [VEC_W-1:0]           idx_vec;
  logic [ADDR_W-1:0]          idx_addr;
  logic                       idx_ok;
  gate_desc_t                 desc;

  assign cls_vec = req_vec_flat;
  assign desc    = mem_rd_data;

  irq_prio_arb #(
    .NCLS     (NCLS),
    .MASK_CLS (MASK_CLS)
  ) u_arb (
    .req     (req),
    .req_vec (cls_vec),
    .ie      (if_flag),
    .hit     (arb_hit),
    .grant   (arb_grant),
    .vec     (arb_vec)
  );

  // In idle the index unit checks the candidate, afterwards it addresses the latched vector
  assign idx_vec = (state == S_IDLE) ? arb_vec : vec_q;

  irq_tbl_index #(
    .ADDR_W (ADDR_W),
    .LIM_W  (LIM_W)
  ) u_idx (
    .base     (tbl_base),
    .limit    (tbl_limit),
    .vec      (idx_vec),
    .addr     (idx_addr),
    .in_range (idx_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      cnt     <= '0;
      nwords  <= '0;
      vec_q   <= '0;
      addr_q  <= '0;
      ridx    <= '0;
      pop_d   <= 1'b0;
      ack_q   <= '0;
      busy_q  <= 1'b0;
      rvec_q  <= '0;
      rsel_q  <= '0;
      roff_q  <= '0;
      rattr_q <= '0;
    end else begin
      ack_q <= '0;
      pop_d <= stk_pop;
      case (state)
        S_IDLE: begin
          if (arb_hit) begin
            wbuf[0] <= cur_ss;
            wbuf[1] <= cur_flags;
            wbuf[2] <= cur_cs;
            wbuf[3] <= cur_eip;
            if (idx_ok) begin
              vec_q   <= arb_vec;
              wbuf[4] <= err_code;
              nwords  <= vec_has_err(arb_vec) ? CNT_W'(5) : CNT_W'(4);
            end else begin
              vec_q   <= GP_VEC;
              wbuf[4] <= DATA_W'({arb_vec, 3'b010});
              nwords  <= CNT_W'(5);
            end
            ack_q  <= arb_grant;
            busy_q <= 1'b1;
            cnt    <= '0;
            state  <= S_PUSH;
          end else if (ret_req) begin
            busy_q <= 1'b1;
            cnt    <= '0;
            ridx   <= '0;
            state  <= S_POP;
          end
        end
        S_PUSH: begin
          addr_q <= idx_addr;
          cnt    <= cnt + 1'b1;
          if (cnt == nwords - 1'b1) state <= S_FREQ;
        end
        S_FREQ: state <= S_FWAIT;
        S_FWAIT: begin
          if (mem_rd_valid) begin
            rvec_q  <= vec_q;
            rsel_q  <= desc.sel;
            roff_q  <= {desc.off_hi, desc.off_lo};
            rattr_q <= desc.attr;
            state   <= S_REDIR;
          end
        end
        S_REDIR: begin
          busy_q <= 1'b0;
          state  <= S_IDLE;
        end
        S_POP: begin
          if (cnt != CNT_W'(NPOP)) cnt <= cnt + 1'b1;
          if (pop_d) begin
            rbuf[ridx] <= stk_rdata;
            ridx       <= ridx + 1'b1;
            if (ridx == 2'd3) state <= S_RDONE;
          end
        end
        S_RDONE: begin
          busy_q <= 1'b0;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign ack         = ack_q;
  assign busy        = busy_q;
  assign stk_push    = (state == S_PUSH);
  assign stk_wdata   = wbuf[cnt];
  assign stk_pop     = (state == S_POP) && (cnt != CNT_W'(NPOP));
  assign mem_rd_req  = (state == S_FREQ);
  assign mem_rd_addr = addr_q;
  assign redir_valid = (state == S_REDIR);
  assign redir_vec   = rvec_q;
  assign redir_sel   = rsel_q;
  assign redir_off   = roff_q;
  assign redir_attr  = rattr_q;
  assign ret_valid   = (state == S_RDONE);
  assign ret_eip     = rbuf[0];
  assign ret_cs      = rbuf[1];
  assign ret_flags   = rbuf[2];
  assign ret_ss      = rbuf[3];

endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int NCLS     = 8,
  parameter int MASK_CLS = 5
) (
  input logic            clk,
  input logic            rst,
  input logic [NCLS-1:0] ack,
  input logic            busy,
  input logic            if_flag,
  input logic            redir_valid,
  input logic            mem_rd_req,
  input logic            stk_push,
  input logic            stk_pop,
  input logic            ret_valid
);

  assert_ack_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack));

  assert_mask_gate_R2: assert property (@(posedge clk) disable iff (rst)
    ack[MASK_CLS] |-> $past(if_flag));

  assert_fetch_in_busy_R3: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |-> busy);

  assert_redir_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    redir_valid |=> !redir_valid);

  assert_redir_busy_R8: assert property (@(posedge clk) disable iff (rst)
    redir_valid |=> !busy);

  assert_no_dispatch_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (|ack) |-> !$past(busy));

  assert_push_pop_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(stk_push && stk_pop));

  assert_ret_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    ret_valid |=> !ret_valid);

endmodule

bind irq_entry_seq irq_entry_seq_chk #(
  .NCLS     (NCLS),
  .MASK_CLS (MASK_CLS)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ack         (ack),
  .busy        (busy),
  .if_flag     (if_flag),
  .redir_valid (redir_valid),
  .mem_rd_req  (mem_rd_req),
  .stk_push    (stk_push),
  .stk_pop     (stk_pop),
  .ret_valid   (ret_valid)
);

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  req = '0;
  logic [7:0][7:0] cv;
  logic [63:0] rvf;
  logic        if_flag = 1'b0;
  logic [31:0] err_code = '0;
  logic [31:0] cur_ss = '0, cur_flags = '0, cur_cs = '0, cur_eip = '0;
  logic [31:0] tbl_base = 32'h0008_0000;
  logic [15:0] tbl_limit = 16'h07FF;
  logic        ret_req = 1'b0;
  logic [7:0]  ack;
  logic        busy;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [63:0] mem_rd_data = '0;
  logic        stk_push;
  logic [31:0] stk_wdata;
  logic        stk_pop;
  logic [31:0] stk_rdata = '0;
  logic        redir_valid;
  logic [7:0]  redir_vec;
  logic [15:0] redir_sel;
  logic [31:0] redir_off;
  logic [15:0] redir_attr;
  logic        ret_valid;
  logic [31:0] ret_eip, ret_cs, ret_flags, ret_ss;

  int checks = 0;
  int fails  = 0;

  assign rvf = cv;

  always #4 clk = ~clk;

  irq_entry_seq u0 (
    .clk(clk), .rst(rst), .req(req), .req_vec_flat(rvf), .if_flag(if_flag),
    .err_code(err_code), .cur_ss(cur_ss), .cur_flags(cur_flags), .cur_cs(cur_cs),
    .cur_eip(cur_eip), .tbl_base(tbl_base), .tbl_limit(tbl_limit), .ret_req(ret_req),
    .ack(ack), .busy(busy), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data), .stk_push(stk_push),
    .stk_wdata(stk_wdata), .stk_pop(stk_pop), .stk_rdata(stk_rdata),
    .redir_valid(redir_valid), .redir_vec(redir_vec), .redir_sel(redir_sel),
    .redir_off(redir_off), .redir_attr(redir_attr), .ret_valid(ret_valid),
    .ret_eip(ret_eip), .ret_cs(ret_cs), .ret_flags(ret_flags), .ret_ss(ret_ss)
  );

  // Memory and stack models
  logic [31:0] stk_mem [0:63];
  int          sp_m = 0;
  logic [31:0] pend_data = '0;
  int          rd_cnt = 0;
  logic [31:0] last_addr = '0;
  int          mdly = 0;

  function automatic logic [63:0] desc_of(input logic [31:0] a);
    return {a[15:0] ^ 16'hA5A5, 8'h8E, 8'h00, a[15:0] + 16'h0100, a[15:0]};
  endfunction

  function automatic bit exp_err(input logic [7:0] v);
    return (v == 8) || (v >= 10 && v <= 14) || (v == 17);
  endfunction

  always @(negedge clk) begin
    mem_rd_valid = 1'b0;
    if (mdly > 0) begin
      mdly = mdly - 1;
      if (mdly == 0) begin
        mem_rd_valid = 1'b1;
        mem_rd_data  = desc_of(last_addr);
      end
    end
    if (mem_rd_req) begin
      rd_cnt    = rd_cnt + 1;
      last_addr = mem_rd_addr;
      mdly      = 3;
    end
    if (stk_push) begin
      stk_mem[sp_m[5:0]] = stk_wdata;
      sp_m = sp_m + 1;
    end
    if (stk_pop) begin
      sp_m = sp_m - 1;
      pend_data = stk_mem[sp_m[5:0]];
    end
  end

  always @(posedge clk) stk_rdata <= pend_data;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_words(input int i);
    cur_ss    = 32'h5500_0000 + i;
    cur_flags = 32'hF1A6_0000 + i;
    cur_cs    = 32'hC500_0000 + i;
    cur_eip   = 32'h1000_0000 + i * 16;
    err_code  = 32'hE000_0000 | i;
  endtask

  task automatic wait_ack(output bit got);
    got = 0;
    for (int t = 0; t < 200; t++) begin
      @(negedge clk);
      if (ack != 0) begin got = 1; break; end
    end
  endtask

  task automatic wait_redir(output int busy_bad);
    busy_bad = 0;
    for (int t = 0; t < 200; t++) begin
      if (!busy) busy_bad++;
      if (redir_valid) break;
      @(negedge clk);
    end
  endtask

  task automatic run_entry(input int i, input logic [7:0] mask, input logic iflg,
                           input logic [7:0] ext, input logic [15:0] lim,
                           input logic [7:0] xvec, input logic [2:0] xcls);
    bit got;
    int bad, sp0, rc0, n;
    logic [31:0] a, xerr;
    bit gp;
    set_words(i);
    cv[5] = ext;
    tbl_limit = lim;
    if_flag = iflg;
    sp0 = sp_m;
    rc0 = rd_cnt;
    req = mask;
    wait_ack(got);
    chk("R1 acknowledged class", ack, 8'(1) << xcls);
    req = '0;
    wait_redir(bad);
    chk("R8 busy held until redirect", bad, 0);
    chk("R8 redirect pulse seen", redir_valid, 1);
    a = tbl_base + {21'd0, xvec, 3'b000};
    chk("R7 redirect vector", redir_vec, xvec);
    chk("R7 handler selector", redir_sel, a[15:0] + 16'h0100);
    chk("R7 handler offset", redir_off, {a[15:0] ^ 16'hA5A5, a[15:0]});
    chk("R7 access field", redir_attr, 16'h8E00);
    chk("R3 descriptor address", last_addr, a);
    chk("R3 single read", rd_cnt - rc0, 1);
    gp = (xvec != cv[xcls]);
    if (gp) chk("R4 fault vector substituted", redir_vec, 13);
    @(negedge clk);
    chk("R8 redirect one cycle", redir_valid, 0);
    chk("R8 busy low after redirect", busy, 0);
    n = exp_err(xvec) ? 5 : 4;
    chk("R6 push count", sp_m - sp0, n);
    chk("R5 push word 0 stack segment", stk_mem[sp0[5:0]], cur_ss);
    chk("R5 push word 1 flags", stk_mem[(sp0 + 1) & 63], cur_flags);
    chk("R5 push word 2 code segment", stk_mem[(sp0 + 2) & 63], cur_cs);
    chk("R5 push word 3 return address", stk_mem[(sp0 + 3) & 63], cur_eip);
    if (n == 5) begin
      xerr = gp ? {21'd0, cv[xcls], 3'b010} : err_code;
      chk("R6 error code word", stk_mem[(sp0 + 4) & 63], xerr);
    end
  endtask

  // mask, if_flag, class-5 vector, limit, expected vector, expected class
  localparam logic [43:0] TV [0:9] = '{
    {8'h20, 1'b1, 8'h40, 16'h07FF, 8'h40, 3'd5},
    {8'hFF, 1'b1, 8'h40, 16'h07FF, 8'd18, 3'd0},
    {8'h30, 1'b1, 8'h40, 16'h07FF, 8'd14, 3'd4},
    {8'hE0, 1'b0, 8'h40, 16'h07FF, 8'd8,  3'd6},
    {8'hA0, 1'b1, 8'h41, 16'h07FF, 8'h41, 3'd5},
    {8'h80, 1'b0, 8'h40, 16'h07FF, 8'd0,  3'd7},
    {8'h20, 1'b1, 8'h40, 16'h01FF, 8'd13, 3'd5},  // R4 one past the limit
    {8'h20, 1'b1, 8'h3F, 16'h01FF, 8'h3F, 3'd5},  // R4 last byte on the limit
    {8'h06, 1'b0, 8'h40, 16'h07FF, 8'd2,  3'd1},
    {8'h60, 1'b0, 8'hF0, 16'h07FF, 8'd8,  3'd6}
  };

  initial begin
    bit got;
    int bad, sp0, nack, nstray;
    cv[0] = 8'd18; cv[1] = 8'd2;  cv[2] = 8'd1; cv[3] = 8'd3;
    cv[4] = 8'd14; cv[5] = 8'h40; cv[6] = 8'd8; cv[7] = 8'd0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 busy after reset", busy, 0);
    chk("R11 ack after reset", ack, 0);
    chk("R11 redirect after reset", redir_valid, 0);
    chk("R11 restore after reset", ret_valid, 0);
    chk("R11 strobes after reset", {stk_push, stk_pop, mem_rd_req}, 0);

    for (int i = 0; i < 10; i++) begin
      logic [43:0] e;
      e = TV[i];
      run_entry(i, e[43:36], e[35], e[34:27], e[26:11], e[10:3], e[2:0]);
      repeat (2) @(negedge clk);
    end

    // R2: maskable class alone with the flag clear
    tbl_limit = 16'h07FF;
    cv[5] = 8'h40;
    if_flag = 1'b0;
    sp0 = sp_m;
    req = 8'h20;
    nack = 0;
    nstray = 0;
    repeat (20) begin
      @(negedge clk);
      if (ack != 0) nack++;
      if (stk_push) nstray++;
    end
    chk("R2 no acknowledge while masked", nack, 0);
    chk("R2 no pushes while masked", nstray + (sp_m - sp0), 0);
    chk("R2 idle while masked", busy, 0);
    if_flag = 1'b1;
    wait_ack(got);
    chk("R2 taken after flag set", ack, 8'h20);
    req = '0;
    wait_redir(bad);
    repeat (3) @(negedge clk);

    // R9: more urgent request arrives during an entry
    set_words(30);
    req = 8'h80;
    wait_ack(got);
    chk("R9 first dispatch class 7", ack, 8'h80);
    req = 8'h01;
    nack = 0;
    for (int t = 0; t < 200; t++) begin
      @(negedge clk);
      if (ack != 0) nack++;
      if (redir_valid) break;
    end
    chk("R9 no dispatch while busy", nack, 0);
    chk("R9 running entry not preempted", redir_vec, 8'd0);
    wait_ack(got);
    chk("R9 pending class taken afterwards", ack, 8'h01);
    req = '0;
    wait_redir(bad);
    repeat (3) @(negedge clk);

    // R10: entry then return
    run_entry(20, 8'h20, 1'b1, 8'h40, 16'h07FF, 8'h40, 3'd5);
    sp0 = sp_m;
    ret_req = 1'b1;
    @(negedge clk);
    ret_req = 1'b0;
    got = 0;
    for (int t = 0; t < 200; t++) begin
      if (ret_valid) begin got = 1; break; end
      @(negedge clk);
    end
    chk("R10 restore pulse seen", got, 1);
    chk("R10 restored return address", ret_eip, 32'h1000_0000 + 20 * 16);
    chk("R10 restored code segment", ret_cs, 32'hC500_0000 + 20);
    chk("R10 restored flags", ret_flags, 32'hF1A6_0000 + 20);
    chk("R10 restored stack segment", ret_ss, 32'h5500_0000 + 20);
    chk("R10 four pops", sp0 - sp_m, 4);
    @(negedge clk);
    chk("R10 restore one cycle", ret_valid, 0);
    chk("R10 idle after return", busy, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R8 watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule